// File: doc/BRIEF.md
# E3 Receive Overhead Interrupt Status

This block sits behind an E3 receive framer. Once per received frame, the framer gives it a set of overhead results: the far-end block error bit, the far-end receive failure bit, a parity (BIP-8) mismatch flag, an alignment-byte error flag and the 3-bit payload type field. A single-cycle frame strobe qualifies these results. The block turns them into a five-bit sticky interrupt status register that clears when it is read. It also drives one interrupt line, masked per bit by a writable enable register.

The far-end receive failure indication (yellow alarm) is not reported raw. A persistence filter declares the alarm after N consecutive frames carrying a 1 and removes it after N consecutive frames carrying a 0. N is 3 or 5, chosen by an input. Both entry to and exit from the alarm raise the same change bit. The filtered alarm level itself can be read at a separate address. Payload type changes between consecutive frames are flagged. The first frame after reset is exempt, because no earlier value exists.

Software reads through a simple register port. Address 0 is the status register, which clears on read. Address 1 is the interrupt enable register, which can be read and written. Address 2 holds the filtered alarm level in bit 0. Address 3 reads as zero.

Top module: `e3oi_top`

## Requirements
- R1: A frame strobe with the far-end block error input at 1 sets status bit 4.
- R2: A frame strobe with the parity mismatch input at 1 sets status bit 2.
- R3: A frame strobe with the alignment-byte error input at 1 sets status bit 1.
- R4: Status bit 0 is set when the 3-bit payload type of a strobed frame differs from that of the previous strobed frame. The first strobed frame after reset never sets it.
- R5: The filtered alarm level (address 2, bit 0) goes to 1 on the frame that completes N consecutive frames with the failure bit at 1. It goes to 0 on the frame that completes N consecutive frames with the bit at 0. N is 3 when the select input is 0 and 5 when it is 1. The select value present at a frame strobe applies to that frame.
- R6: Status bit 3 is set on every change of the filtered alarm level, in either direction.
- R7: The consecutive-frame count restarts whenever a frame's failure bit differs from the value being counted. For example, with N=3, the sequence 1,1,0,1,1 does not declare the alarm.
- R8: A read of address 0 returns the status bits in positions 4..0 and then clears them. Without such a read, a set status bit stays set. Reads of other addresses clear nothing.
- R9: An event arriving in the same cycle as a status read stays set after that read.
- R10: The interrupt output is 1 exactly when some status bit and the matching bit of the enable register (address 1, bits 4..0, read/write) are both 1.
- R11: Overhead inputs have no effect on status or alarm level while the frame strobe is 0.
- R12: After reset, the status, enable and filtered alarm level are all 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe qualifying the frame's overhead results |
| febe_bit | input | 1 | Far-end block error bit of the frame |
| ferf_bit | input | 1 | Far-end receive failure bit of the frame |
| bip_err | input | 1 | Frame judged errored by parity |
| fa_err | input | 1 | Error seen in the alignment bytes |
| ptype | input | 3 | Payload type field of the frame |
| persist_long | input | 1 | Alarm persistence select: 0 gives N=3, 1 gives N=5 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Read data, combinational from address |
| irq | output | 1 | Masked interrupt output |

## Verification
The assertions assume that the frame strobe lasts one cycle per frame and that the overhead inputs are valid whenever it is high. They also assume that a read and a write to the register port never happen in the same cycle. The bench drives every frame as a single-cycle strobe, changes all inputs on the falling clock edge, and issues reads and writes in separate cycles. Between frames it deliberately toggles the overhead inputs with the strobe low, to exercise the qualification.

// File: rtl/e3oi_pkg.sv
package e3oi_pkg;
   localparam int ST_W   = 5;
   localparam int B_FEBE = 4;
   localparam int B_FERF = 3;
   localparam int B_BIP  = 2;
   localparam int B_FA   = 1;
   localparam int B_PT   = 0;

   typedef enum logic [1:0] {
      RA_STAT = 2'd0,
      RA_EN   = 2'd1,
      RA_LINK = 2'd2,
      RA_NONE = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/e3oi_ferf_filter.sv
module e3oi_ferf_filter #(
   parameter int N_SHORT = 3,
   parameter int N_LONG  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done,
   input  logic ferf_bit,
   input  logic persist_long,
   output logic alarm,
   output logic alarm_chg
);
   localparam int CNT_W = $clog2(N_LONG + 1);

   generate
      if (N_SHORT < 1 || N_LONG < N_SHORT) begin : g_bad_n
         $error("e3oi_ferf_filter: need 1 <= N_SHORT <= N_LONG");
      end
   endgenerate

   logic             run_val;
   logic [CNT_W-1:0] cnt, cnt_nx, lim;

   always_comb begin
      if (ferf_bit != run_val)          cnt_nx = CNT_W'(1);
      else if (cnt == CNT_W'(N_LONG))   cnt_nx = cnt;
      else                              cnt_nx = cnt + CNT_W'(1);
      lim       = persist_long ? CNT_W'(N_LONG) : CNT_W'(N_SHORT);
      alarm_chg = frame_done && (cnt_nx >= lim) && (ferf_bit != alarm);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_val <= 1'b0;
         cnt     <= '0;
         alarm   <= 1'b0;
      end else if (frame_done) begin
         run_val <= ferf_bit;
         cnt     <= cnt_nx;
         if (alarm_chg) alarm <= ferf_bit;
      end
   end

   // R11
   alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(alarm));

   // R6
   alarm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_chg |=> (alarm != $past(alarm)));

   // R5
   alarm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_chg |=> (alarm == $past(ferf_bit)));
endmodule

// File: rtl/e3oi_ptype_watch.sv
module e3oi_ptype_watch #(
   parameter int PT_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_done,
   input  logic [PT_W-1:0] ptype,
   output logic            pt_mis
);
   generate
      if (PT_W < 1) begin : g_bad_w
         $error("e3oi_ptype_watch: PT_W must be positive");
      end
   endgenerate

   logic            have_prev;
   logic [PT_W-1:0] prev;

   assign pt_mis = frame_done && have_prev && (ptype != prev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev      <= '0;
      end else if (frame_done) begin
         have_prev <= 1'b1;
         prev      <= ptype;
      end
   end

   // R4
   first_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !have_prev |-> !pt_mis);
endmodule

// File: rtl/e3oi_status_bank.sv
module e3oi_status_bank #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev,
   input  logic         clr,
   output logic [W-1:0] st
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     bit_q <= 1'b0;
            else if (ev[i]) bit_q <= 1'b1;
            else if (clr)   bit_q <= 1'b0;
         end
         assign st[i] = bit_q;
      end
   endgenerate

   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((st & $past(st)) == $past(st)));

   // R9
   keep_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((st & $past(ev)) == $past(ev)));

   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ev == '0) |=> (st == '0));
endmodule

// File: rtl/e3oi_top.sv
module e3oi_top
   import e3oi_pkg::*;
#(
   parameter int PT_W    = 3,
   parameter int N_SHORT = 3,
   parameter int N_LONG  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_done,
   input  logic            febe_bit,
   input  logic            ferf_bit,
   input  logic            bip_err,
   input  logic            fa_err,
   input  logic [PT_W-1:0] ptype,
   input  logic            persist_long,
   input  logic            reg_rd,
   input  logic            reg_wr,
   input  logic [1:0]      reg_addr,
   input  logic [ST_W-1:0] reg_wdata,
   output logic [ST_W-1:0] reg_rdata,
   output logic            irq
);
   logic            alarm, alarm_chg, pt_mis, rd_clr;
   logic [ST_W-1:0] ev, st, en_q;

   e3oi_ferf_filter #(.N_SHORT(N_SHORT), .N_LONG(N_LONG)) u_filt (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .ferf_bit(ferf_bit),
      .persist_long(persist_long), .alarm(alarm), .alarm_chg(alarm_chg));

   e3oi_ptype_watch #(.PT_W(PT_W)) u_pt (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .ptype(ptype),
      .pt_mis(pt_mis));

   always_comb begin
      ev         = '0;
      ev[B_FEBE] = frame_done & febe_bit;
      ev[B_FERF] = alarm_chg;
      ev[B_BIP]  = frame_done & bip_err;
      ev[B_FA]   = frame_done & fa_err;
      ev[B_PT]   = pt_mis;
   end

   assign rd_clr = reg_rd && (reg_addr == RA_STAT);

   e3oi_status_bank #(.W(ST_W)) u_st (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr(rd_clr), .st(st));

   always_ff @(posedge clk) begin
      if (!rst_n)                          en_q <= '0;
      else if (reg_wr && reg_addr == RA_EN) en_q <= reg_wdata;
   end

   always_comb begin
      case (reg_addr)
         RA_STAT: reg_rdata = st;
         RA_EN:   reg_rdata = en_q;
         RA_LINK: reg_rdata = {{(ST_W-1){1'b0}}, alarm};
         default: reg_rdata = '0;
      endcase
   end

   assign irq = |(st & en_q);

   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);

   // R11
   idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !rd_clr) |=> $stable(st));
endmodule

// File: tb/e3oi_top_bench.sv
module e3oi_top_bench;
   logic       clk = 1'b0;
   logic       rst_n, frame_done, febe_bit, ferf_bit, bip_err, fa_err;
   logic [2:0] ptype;
   logic       persist_long, reg_rd, reg_wr;
   logic [1:0] reg_addr;
   logic [4:0] reg_wdata, reg_rdata;
   logic       irq;
   int         total = 0, bad = 0;
   logic [4:0] rv;

   always #4 clk = ~clk;

   e3oi_top u_e3oi_top (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .febe_bit(febe_bit),
      .ferf_bit(ferf_bit), .bip_err(bip_err), .fa_err(fa_err), .ptype(ptype),
      .persist_long(persist_long), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq));

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic sel);
      @(negedge clk);
      rst_n = 1'b0; frame_done = 0; febe_bit = 0; ferf_bit = 0; bip_err = 0;
      fa_err = 0; ptype = 3'd0; persist_long = sel; reg_rd = 0; reg_wr = 0;
      reg_addr = 2'd0; reg_wdata = 5'd0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic frame(input logic fb, input logic ff, input logic bp,
                        input logic fa, input logic [2:0] pt);
      @(negedge clk);
      frame_done = 1; febe_bit = fb; ferf_bit = ff; bip_err = bp; fa_err = fa; ptype = pt;
      @(negedge clk);
      frame_done = 0; febe_bit = 0; bip_err = 0; fa_err = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [4:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [4:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic t_reset;
      do_reset(0);
      rd(2'd0, rv); chk("R12 status", rv, 5'h00);
      rd(2'd1, rv); chk("R12 enable", rv, 5'h00);
      rd(2'd2, rv); chk("R12 alarm", rv, 5'h00);
      chk("R12 irq", {4'd0, irq}, 5'h00);
   endtask

   task automatic t_events;
      do_reset(0);
      frame(1, 0, 0, 0, 3'd2);
      rd(2'd0, rv); chk("R1 febe and R4 first frame", rv, 5'h10);
      rd(2'd0, rv); chk("R8 clear after read", rv, 5'h00);
      frame(0, 0, 1, 0, 3'd2);
      rd(2'd2, rv); chk("R8 other read no clear", rv, 5'h00);
      rd(2'd0, rv); chk("R2 bip", rv, 5'h04);
      frame(0, 0, 0, 1, 3'd2);
      frame(0, 0, 0, 0, 3'd2);
      rd(2'd0, rv); chk("R3 fa sticky", rv, 5'h02);
      frame(0, 0, 0, 0, 3'd7);
      rd(2'd0, rv); chk("R4 ptype change", rv, 5'h01);
      frame(0, 0, 0, 0, 3'd7);
      rd(2'd0, rv); chk("R4 same ptype", rv, 5'h00);
   endtask

   task automatic t_same_cycle;
      do_reset(0);
      @(negedge clk);
      frame_done = 1; febe_bit = 1; reg_addr = 2'd0; reg_rd = 1;
      #1 rv = reg_rdata;
      chk("R9 read before event", rv, 5'h00);
      @(negedge clk);
      frame_done = 0; febe_bit = 0; reg_rd = 0;
      rd(2'd0, rv); chk("R9 event kept", rv, 5'h10);
   endtask

   task automatic t_filter_short;
      do_reset(0);
      frame(0, 1, 0, 0, 0); frame(0, 1, 0, 0, 0);
      rd(2'd2, rv); chk("R5 not yet", rv, 5'h00);
      frame(0, 1, 0, 0, 0);
      rd(2'd2, rv); chk("R5 entry N=3", rv, 5'h01);
      rd(2'd0, rv); chk("R6 entry change", rv, 5'h08);
      frame(0, 0, 0, 0, 0); frame(0, 0, 0, 0, 0);
      rd(2'd2, rv); chk("R5 exit not yet", rv, 5'h01);
      frame(0, 0, 0, 0, 0);
      rd(2'd2, rv); chk("R5 exit N=3", rv, 5'h00);
      rd(2'd0, rv); chk("R6 exit change", rv, 5'h08);
      frame(0, 1, 0, 0, 0); frame(0, 1, 0, 0, 0); frame(0, 0, 0, 0, 0);
      frame(0, 1, 0, 0, 0); frame(0, 1, 0, 0, 0);
      rd(2'd2, rv); chk("R7 restart", rv, 5'h00);
      rd(2'd0, rv); chk("R7 no change", rv, 5'h00);
      frame(0, 1, 0, 0, 0);
      rd(2'd2, rv); chk("R7 entry after restart", rv, 5'h01);
   endtask

   task automatic t_filter_long;
      do_reset(1);
      for (int i = 0; i < 4; i++) frame(0, 1, 0, 0, 0);
      rd(2'd2, rv); chk("R5 N=5 four frames", rv, 5'h00);
      frame(0, 1, 0, 0, 0);
      rd(2'd2, rv); chk("R5 N=5 entry", rv, 5'h01);
      for (int i = 0; i < 3; i++) frame(0, 0, 0, 0, 0);
      rd(2'd2, rv); chk("R5 N=5 holds after three", rv, 5'h01);
      persist_long = 0;
      frame(0, 0, 0, 0, 0);
      rd(2'd2, rv); chk("R5 switch to N=3 applies", rv, 5'h00);
   endtask

   task automatic t_ignore;
      do_reset(0);
      frame(0, 0, 0, 0, 3'd1);
      @(negedge clk);
      febe_bit = 1; ferf_bit = 1; bip_err = 1; fa_err = 1; ptype = 3'd6;
      repeat (6) @(negedge clk);
      febe_bit = 0; ferf_bit = 0; bip_err = 0; fa_err = 0; ptype = 3'd1;
      rd(2'd0, rv); chk("R11 status untouched", rv, 5'h00);
      rd(2'd2, rv); chk("R11 alarm untouched", rv, 5'h00);
   endtask

   task automatic t_irq;
      do_reset(0);
      wr(2'd1, 5'h04);
      rd(2'd1, rv); chk("R10 enable readback", rv, 5'h04);
      frame(1, 0, 0, 0, 0);
      #1 chk("R10 masked bit", {4'd0, irq}, 5'h00);
      frame(0, 0, 1, 0, 0);
      #1 chk("R10 enabled bit", {4'd0, irq}, 5'h01);
      rd(2'd0, rv); chk("R10 status", rv, 5'h14);
      #1 chk("R10 irq drops on clear", {4'd0, irq}, 5'h00);
   endtask

   initial begin
      rst_n = 0;
      t_reset;
      t_events;
      t_same_cycle;
      t_filter_short;
      t_filter_long;
      t_ignore;
      t_irq;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule